// File: doc/BRIEF.md
# Atomic Read-Modify-Write and Parity Front End for an SRAM Channel

This block sits between a requester and one synchronous SRAM channel whose stored word is 18 bits: two 8-bit data bytes, each followed by its own even-parity bit. A requester hands it a command with an address, a 16-bit operand and a tag. The command is a plain read, a plain write, or one of five atomic operations: swap, bit set, bit clear, add and subtract. An atomic command reads the word, changes it and writes it back. It returns the value the word held before the change.

The unit serves one command at a time. A read goes to memory, and then either a response or a write-back follows. No other access can reach the SRAM between the read half and the write half of an atomic operation, so each atomic is indivisible. Responses come back in the same order as the requests and carry the request's tag.

A channel-level parity enable selects between two modes. With it on, writes store even parity and reads check it. With it off, the parity bits are stored as zero and never checked, so a 16-bit-wide memory can be used. A read that fails the check marks its response. It also sets a sticky error flag, which holds the address of the first failure.

Top module: `sram_rmw_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, rsp_valid is 0, mem_en is 0 and perr_flag is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 0 in the cycle after acceptance and stays 0 until the response has been given. Each accepted request yields exactly one single-cycle rsp_valid pulse, with rsp_tag equal to the request's tag, in request order.
- R3: Opcode 1 (write) stores the operand with one memory write. The stored word places data bits 7:0 at bits 7:0 and data bits 15:8 at bits 16:9. Bit 8 holds the even parity (XOR) of data byte 0, and bit 17 holds the even parity of data byte 1. The response carries data 0 and no parity error.
- R4: Opcode 0 (read) and the reserved opcode 7 make one memory read and nothing else. They return the stored data bits.
- R5: Opcode 2 (swap) returns the old data and stores the operand.
- R6: Opcode 3 (bit set) stores old OR operand. Opcode 4 (bit clear) stores old AND NOT operand. Both return the old data.
- R7: Opcode 5 (add) stores old plus operand, and opcode 6 (subtract) stores old minus operand. Both wrap modulo 2^16 and return the old data.
- R8: Every atomic opcode (2 to 6) issues exactly one memory read followed by exactly one memory write to the same address. The memory is idle in the cycle between them, and there is no other memory access in between.
- R9: With par_en at 0, written words carry 0 in bits 8 and 17, and reads never report a parity error.
- R10: With par_en at 1, a read whose stored byte and parity bit together hold an odd number of ones sets rsp_perr on that response. It also sets perr_flag, which stays 1 until reset. perr_addr holds the address of the first such failure and does not change on later failures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_en | input | 1 | Channel parity enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 3 | Opcode (0 read, 1 write, 2 swap, 3 set, 4 clear, 5 add, 6 subtract, 7 read) |
| req_addr | input | ADDR_W | Word address |
| req_data | input | 16 | Write data or atomic operand |
| req_tag | input | TAG_W | Requester tag |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 16 | Old or read data (0 for writes) |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_perr | output | 1 | Parity failure on this response's read |
| perr_flag | output | 1 | Sticky parity error flag |
| perr_addr | output | ADDR_W | Address of the first parity failure |
| mem_en | output | 1 | SRAM access strobe |
| mem_we | output | 1 | SRAM write select |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | 18 | SRAM write word |
| mem_rdata | input | 18 | SRAM read word, valid one cycle after a read strobe |

## Verification
The assertions assume the attached SRAM returns read data exactly one cycle after a read strobe. They also assume that reset is applied before the first request. They make no assumption about the request inputs beyond the handshake, so req_valid may be held high while the unit is busy. The stimulus uses a memory model with that one-cycle latency. It mixes random opcodes over a small set of addresses, so atomics often hit words that were just written. It flips par_en now and then, and it corrupts stored parity bits directly in the model to create read failures.

// File: rtl/sram_rmw_pkg.sv
package sram_rmw_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_SET   = 3'd3,
    OP_CLR   = 3'd4,
    OP_ADD   = 3'd5,
    OP_SUB   = 3'd6,
    OP_RSVD  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_MEM  = 3'd1,
    S_CHK  = 3'd2,
    S_WB   = 3'd3,
    S_DONE = 3'd4
  } st_e;

  function automatic logic op_is_atomic(op_e op);
    return (op == OP_SWAP) || (op == OP_SET) || (op == OP_CLR) ||
           (op == OP_ADD)  || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/sram_par_enc.sv
module sram_par_enc #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int DATA_W = BYTE_W * NBYTES,
  localparam int WORD_W = (BYTE_W + 1) * NBYTES
) (
  input  logic              par_en,
  input  logic [DATA_W-1:0] data,
  output logic [WORD_W-1:0] word
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign word[i*(BYTE_W+1) +: BYTE_W] = data[i*BYTE_W +: BYTE_W];
    assign word[i*(BYTE_W+1) + BYTE_W]  = par_en & (^data[i*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/sram_par_chk.sv
module sram_par_chk #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int DATA_W = BYTE_W * NBYTES,
  localparam int WORD_W = (BYTE_W + 1) * NBYTES
) (
  input  logic [WORD_W-1:0] word,
  output logic [DATA_W-1:0] data,
  output logic [NBYTES-1:0] bad
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign data[i*BYTE_W +: BYTE_W] = word[i*(BYTE_W+1) +: BYTE_W];
    assign bad[i] = ^word[i*(BYTE_W+1) +: (BYTE_W+1)];
  end
endmodule

// File: rtl/sram_rmw_alu.sv
module sram_rmw_alu
  import sram_rmw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] new_val
);
  always_comb begin
    case (op)
      OP_SWAP: new_val = opnd;
      OP_SET:  new_val = old_val | opnd;
      OP_CLR:  new_val = old_val & ~opnd;
      OP_ADD:  new_val = old_val + opnd;
      OP_SUB:  new_val = old_val - opnd;
      default: new_val = old_val;
    endcase
  end
endmodule

// File: rtl/sram_err_log.sv
module sram_err_log #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  output logic              flag,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      addr <= '0;
    end else if (hit && !flag) begin
      flag <= 1'b1;
      addr <= hit_addr;
    end
  end

  // R10: the flag only clears through reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(flag) |-> flag);

  // R10: the first failing address is kept
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (flag && $past(flag)) |-> $stable(addr));
endmodule

// File: rtl/sram_rmw_unit.sv
module sram_rmw_unit
  import sram_rmw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 4,
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int DATA_W = BYTE_W * NBYTES,
  localparam int WORD_W = (BYTE_W + 1) * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_perr,
  output logic              perr_flag,
  output logic [ADDR_W-1:0] perr_addr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);

  st_e               st;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opnd_q;
  logic [TAG_W-1:0]  tag_q;

  logic [DATA_W-1:0] rd_data;
  logic [NBYTES-1:0] bad_vec;
  logic [DATA_W-1:0] alu_out;
  logic [DATA_W-1:0] enc_in;
  logic [WORD_W-1:0] enc_word;
  logic              rd_bad;
  logic              log_hit;

  assign req_ready = (st == S_IDLE);
  assign enc_in    = (st == S_IDLE) ? req_data : alu_out;
  assign rd_bad    = par_en && (|bad_vec);
  assign log_hit   = (st == S_CHK) && rd_bad;

  sram_par_chk #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_chk (
    .word (mem_rdata),
    .data (rd_data),
    .bad  (bad_vec)
  );

  sram_rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (op_q),
    .old_val (rd_data),
    .opnd    (opnd_q),
    .new_val (alu_out)
  );

  sram_par_enc #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_enc (
    .par_en (par_en),
    .data   (enc_in),
    .word   (enc_word)
  );

  sram_err_log #(.ADDR_W(ADDR_W)) u_log (
    .clk      (clk),
    .rst      (rst),
    .hit      (log_hit),
    .hit_addr (addr_q),
    .flag     (perr_flag),
    .addr     (perr_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      op_q      <= OP_READ;
      addr_q    <= '0;
      opnd_q    <= '0;
      tag_q     <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_tag   <= '0;
      rsp_perr  <= 1'b0;
    end else begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            op_q      <= op_e'(req_op);
            addr_q    <= req_addr;
            opnd_q    <= req_data;
            tag_q     <= req_tag;
            mem_en    <= 1'b1;
            mem_we    <= (op_e'(req_op) == OP_WRITE);
            mem_addr  <= req_addr;
            mem_wdata <= enc_word;
            st        <= S_MEM;
          end
        end
        S_MEM: begin
          if (op_q == OP_WRITE) begin
            rsp_valid <= 1'b1;
            rsp_data  <= '0;
            rsp_perr  <= 1'b0;
            rsp_tag   <= tag_q;
            st        <= S_DONE;
          end else begin
            st        <= S_CHK;
          end
        end
        S_CHK: begin
          rsp_data <= rd_data;
          rsp_perr <= rd_bad;
          rsp_tag  <= tag_q;
          if (op_is_atomic(op_q)) begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= addr_q;
            mem_wdata <= enc_word;
            st        <= S_WB;
          end else begin
            rsp_valid <= 1'b1;
            st        <= S_DONE;
          end
        end
        S_WB: begin
          rsp_valid <= 1'b1;
          st        <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: a write-back is preceded by a read of the same word, with an idle cycle between them
  a_r8_atomic_pair: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && st == S_WB) |->
      ($past(mem_en, 2) && !$past(mem_we, 2) && !$past(mem_en) &&
       $past(mem_addr, 2) == mem_addr));

  // R2: no second acceptance directly after one
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R2: responses are single-cycle pulses
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R2: a response never coexists with an accept
  a_r2_rsp_not_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

endmodule

// File: tb/sim_sram_rmw_unit.sv
module sim_sram_rmw_unit;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic par_en = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [TW-1:0] req_tag = '0;
  logic rsp_valid, rsp_perr, perr_flag;
  logic [15:0] rsp_data;
  logic [TW-1:0] rsp_tag;
  logic [AW-1:0] perr_addr;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [17:0] mem_wdata;
  logic [17:0] mem_rdata = '0;

  logic [17:0] sram [1<<AW];

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [TW-1:0] tag_ctr = '0;
  logic exp_flag = 1'b0;
  logic [AW-1:0] exp_faddr = '0;

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) sram[mem_addr] <= mem_wdata;
      else        mem_rdata <= sram[mem_addr];
    end
  end

  sram_rmw_unit #(.ADDR_W(AW), .TAG_W(TW)) u0 (
    .clk(clk), .rst(rst), .par_en(par_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
    .rsp_perr(rsp_perr), .perr_flag(perr_flag), .perr_addr(perr_addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] enc(input logic [15:0] d, input logic pe);
    return {pe & (^d[15:8]), d[15:8], pe & (^d[7:0]), d[7:0]};
  endfunction

  function automatic logic [15:0] model_alu(input logic [2:0] op,
                                            input logic [15:0] o, input logic [15:0] d);
    case (op)
      3'd2: return d;
      3'd3: return o | d;
      3'd4: return o & ~d;
      3'd5: return o + d;
      3'd6: return o - d;
      default: return o;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      3'd5, 3'd6: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic do_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [15:0] d);
    logic [17:0] w0;
    logic [15:0] old_d, exp_rsp;
    logic exp_bad, atomic, got;
    logic [TW-1:0] t;
    int acc_n;
    logic [AW-1:0] acc_a [4];
    logic acc_w [4];
    string rq;
    rq = req_of(op);
    atomic = (op >= 3'd2) && (op <= 3'd6);
    t = tag_ctr;
    tag_ctr = tag_ctr + 1'b1;
    @(negedge clk);
    w0 = sram[a];
    old_d = {w0[16:9], w0[7:0]};
    exp_bad = (op != 3'd1) && par_en && ((^w0[8:0]) || (^w0[17:9]));
    exp_rsp = (op == 3'd1) ? 16'h0 : old_d;
    chk(req_ready === 1'b1, "R2", "ready before request", {31'd0, req_ready}, 1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_tag = t;
    acc_n = 0;
    got = 1'b0;
    for (int c = 0; c < 12 && !got; c++) begin
      @(negedge clk);
      if (c == 0) begin
        chk(req_ready === 1'b0, "R2", "ready after accept", {31'd0, req_ready}, 0);
        req_valid = 1'b0;
      end
      if (mem_en === 1'b1) begin
        if (acc_n < 4) begin
          acc_a[acc_n] = mem_addr;
          acc_w[acc_n] = mem_we;
        end
        acc_n++;
      end
      if (rsp_valid === 1'b1) got = 1'b1;
    end
    chk(got, "R2", "response seen", {31'd0, got}, 1);
    if (!got) return;
    chk(rsp_tag === t, "R2", "tag", {28'd0, rsp_tag}, {28'd0, t});
    chk(rsp_data === exp_rsp, rq, "response data", {16'd0, rsp_data}, {16'd0, exp_rsp});
    chk(rsp_perr === exp_bad, exp_bad ? "R10" : "R9", "rsp_perr",
        {31'd0, rsp_perr}, {31'd0, exp_bad});
    if (atomic) begin
      chk(acc_n == 2 && acc_w[0] == 1'b0 && acc_w[1] == 1'b1 &&
          acc_a[0] == a && acc_a[1] == a, "R8", "read then write same word",
          acc_n, 2);
    end else begin
      chk(acc_n == 1 && acc_w[0] == (op == 3'd1) && acc_a[0] == a,
          rq, "single access", acc_n, 1);
    end
    if (op == 3'd1) begin
      chk(sram[a] === enc(d, par_en), par_en ? "R3" : "R9", "stored word",
          {14'd0, sram[a]}, {14'd0, enc(d, par_en)});
    end else if (atomic) begin
      chk(sram[a] === enc(model_alu(op, old_d, d), par_en), rq, "stored result",
          {14'd0, sram[a]}, {14'd0, enc(model_alu(op, old_d, d), par_en)});
    end
    if (exp_bad && !exp_flag) begin
      exp_flag = 1'b1;
      exp_faddr = a;
    end
    chk(perr_flag === exp_flag, "R10", "sticky flag", {31'd0, perr_flag}, {31'd0, exp_flag});
    if (exp_flag)
      chk(perr_addr === exp_faddr, "R10", "failing address",
          {24'd0, perr_addr}, {24'd0, exp_faddr});
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240917;
    void'($urandom(seed));
    for (int i = 0; i < (1 << AW); i++) sram[i] = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_en === 1'b0 && perr_flag === 1'b0,
        "R1", "reset outputs", {28'd0, req_ready, rsp_valid, mem_en, perr_flag}, 32'h8);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_en === 1'b0 && perr_flag === 1'b0,
        "R1", "after reset", {28'd0, req_ready, rsp_valid, mem_en, perr_flag}, 32'h8);

    // R3, R4: write then read back
    do_op(3'd1, 8'd3, 16'h1234);
    do_op(3'd0, 8'd3, 16'h0);
    // R7: add and subtract wrap
    do_op(3'd1, 8'd4, 16'hFFFF);
    do_op(3'd5, 8'd4, 16'h0001);
    do_op(3'd6, 8'd4, 16'h0001);
    do_op(3'd0, 8'd4, 16'h0);
    // R6: set then clear
    do_op(3'd1, 8'd5, 16'h0F0F);
    do_op(3'd3, 8'd5, 16'h00F0);
    do_op(3'd4, 8'd5, 16'h0F00);
    do_op(3'd0, 8'd5, 16'h0);
    // R5: swap
    do_op(3'd1, 8'd6, 16'hAAAA);
    do_op(3'd2, 8'd6, 16'h5555);
    // R4: reserved opcode behaves as a read
    do_op(3'd7, 8'd6, 16'hFFFF);
    // R9: parity off stores zero parity bits and reports nothing
    par_en = 1'b0;
    do_op(3'd1, 8'd7, 16'h0101);
    do_op(3'd0, 8'd7, 16'h0);
    // R10: re-enabled parity flags the word written without it
    par_en = 1'b1;
    do_op(3'd0, 8'd7, 16'h0);
    // R10: a later failure keeps the first address
    do_op(3'd1, 8'd9, 16'h00FF);
    @(negedge clk);
    sram[9][17] = ~sram[9][17];
    do_op(3'd5, 8'd9, 16'h0003);

    // random mix over a small address window
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      logic [AW-1:0] a;
      logic [15:0] d;
      op = 3'($urandom_range(0, 7));
      a = AW'($urandom_range(0, 15));
      d = 16'($urandom);
      par_en = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 15) == 0) begin
        @(negedge clk);
        if ($urandom_range(0, 1) == 0) sram[a][8] = ~sram[a][8];
        else                            sram[a][17] = ~sram[a][17];
      end
      do_op(op, a, d);
    end
    finish_run();
  end
endmodule